// File: doc/BRIEF.md
# CRC-32 Accumulator with Timed Restart

A memory-mapped 32-bit CRC accumulator on a single-cycle register bus. Each word written to the data register is folded into a running CRC, and a read of the same register returns the current value. The engine uses the polynomial 0x04C11DB7 with a seed of 0xFFFFFFFF. It takes in each word most significant bit first within one clock and applies no output XOR.

Writing 1 to the restart bit of the control register re-seeds the CRC. The restart is not instantaneous. It opens a guard window of a fixed number of cycles, `GUARD_CYC` (default 2), during which data-register writes are dropped without notice. The restart bit reads back as 1 until the window has closed, so software can poll it before it feeds data. Hardware clears the bit; software never writes it back to 0.

Top module: `crc_accum_top`

## Requirements
- R1: After the asynchronous power-on reset, the data register (byte address 0x0) reads 0xFFFFFFFF, and bit 0 of the control register (byte address 0x8) reads 0.
- R2: A data-register write accepted outside a guard window replaces the CRC with the result of folding the 32-bit word into it: polynomial 0x04C11DB7, bits taken from bit 31 down to bit 0, no reflection, no output XOR. The new value is visible to a read issued in the next cycle.
- R3: A write to address 0x8 with bit 0 set re-seeds the CRC to 0xFFFFFFFF, and a read in the next cycle sees that value.
- R4: A data-register write issued in either of the two cycles that directly follow a restart write is dropped, and the CRC stays 0xFFFFFFFF.
- R5: A data-register write issued in the third cycle after a restart write (two idle cycles between them) or later is accepted and folded into the CRC.
- R6: Bit 0 of the control register reads 1 when read in either of the two cycles after a restart write. It reads 0 from the third cycle on, with no write from software.
- R7: A read of the control register inside the guard window does not shorten it: a data write in the cycle after such a read, still inside the window, is dropped.
- R8: Writing the control register with bit 0 clear has no effect on the CRC or on the restart bit, and a data write in the next cycle is accepted.
- R9: A restart write issued while a guard window is open restarts the window from its full length.
- R10: Read data appears one cycle after the read address. Control reads return the restart bit in bit 0 with all other bits 0. Reads of unmapped addresses, and any cycle without a read in the cycle before it, return 0.
- R11: Writes to unmapped addresses change neither the CRC nor the restart bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus transfer in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |

## Verification
The hardest case to produce is a data write that lands on the exact cycle the guard window closes, or one cycle before it. A bus model that inserts spacing of its own would hide the boundary. The bench therefore drives every transfer on a fixed falling edge with no idle cycles added. A table walk places the data write 0 to 4 idle cycles after the restart write. Directed sequences then put a control read, a second restart, or a zero write to the restart bit inside the window.

// File: rtl/crc_accum_pkg.sv
package crc_accum_pkg;

   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_DATA = 2'd1,
      RSEL_CTRL = 2'd2
   } rd_sel_e;

   typedef struct packed {
      logic    data_wr;
      logic    restart;
      logic    rd;
      rd_sel_e rd_sel;
   } bus_dec_t;

endpackage

// File: rtl/crc_accum_regdec.sv
module crc_accum_regdec
   import crc_accum_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_OFS = 0,
   parameter int unsigned CTRL_OFS = 8
) (
   input  logic              valid,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic              restart_bit,
   output bus_dec_t          dec
);

   localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_OFS);
   localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_OFS);

   generate
      if (DATA_OFS == CTRL_OFS) begin : g_bad_map
         $error("crc_accum_regdec: register offsets collide");
      end
      if (DATA_OFS >= (1 << ADDR_W) || CTRL_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
         $error("crc_accum_regdec: offset outside address space");
      end
   endgenerate

   logic hit_data, hit_ctrl;

   always_comb begin
      hit_data    = (addr == DataA);
      hit_ctrl    = (addr == CtrlA);
      dec.data_wr = valid & we & hit_data;
      dec.restart = valid & we & hit_ctrl & restart_bit;
      dec.rd      = valid & ~we;
      if (hit_data)      dec.rd_sel = RSEL_DATA;
      else if (hit_ctrl) dec.rd_sel = RSEL_CTRL;
      else               dec.rd_sel = RSEL_NONE;
   end

endmodule

// File: rtl/crc_accum_guard.sv
module crc_accum_guard #(
   parameter int unsigned GUARD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int unsigned CNT_W = $clog2(GUARD_CYC + 1);
   localparam logic [CNT_W-1:0] FullCnt = CNT_W'(GUARD_CYC);

   generate
      if (GUARD_CYC < 1) begin : g_bad_guard
         $error("crc_accum_guard: GUARD_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (start)         cnt_q <= FullCnt;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   p_window_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   p_window_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q == CNT_W'(1) && !start) |=> !busy);

   p_restart_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy && cnt_q == FullCnt));

endmodule

// File: rtl/crc_accum_engine.sv
module crc_accum_engine #(
   parameter int unsigned   CRC_W  = 32,
   parameter int unsigned   DATA_W = 32,
   parameter logic [31:0]   POLY   = 32'h04C1_1DB7,
   parameter logic [31:0]   SEED   = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reseed,
   input  logic              wr_en,
   input  logic              hold,
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc
);

   localparam logic [CRC_W-1:0] PolyW = CRC_W'(POLY);
   localparam logic [CRC_W-1:0] SeedW = CRC_W'(SEED);

   generate
      if (CRC_W < 2 || CRC_W > 32) begin : g_bad_crc_w
         $error("crc_accum_engine: CRC_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
         $error("crc_accum_engine: DATA_W out of range");
      end
   endgenerate

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] stage [DATA_W+1];
   logic             accept;

   assign stage[0] = crc_q;

   generate
      for (genvar g = 0; g < DATA_W; g++) begin : g_bit
         logic fb;
         assign fb         = stage[g][CRC_W-1] ^ data[DATA_W-1-g];
         assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? PolyW : '0);
      end
   endgenerate

   assign accept = wr_en & ~hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= SeedW;
      else if (reseed) crc_q <= SeedW;
      else if (accept) crc_q <= stage[DATA_W];
   end

   assign crc = crc_q;

   p_reseed_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reseed |=> (crc == SeedW));

   p_drop_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !reseed) |=> $stable(crc));

   p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !reseed) |=> $stable(crc));

endmodule

// File: rtl/crc_accum_top.sv
module crc_accum_top
   import crc_accum_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned BUS_W     = 32,
   parameter int unsigned GUARD_CYC = 2,
   parameter int unsigned DATA_OFS  = 0,
   parameter int unsigned CTRL_OFS  = 8,
   parameter int unsigned RST_BIT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata
);

   generate
      if (RST_BIT >= BUS_W) begin : g_bad_bit
         $error("crc_accum_top: RST_BIT outside bus");
      end
      if (BUS_W != 32) begin : g_bad_bus
         $error("crc_accum_top: bus must be 32 bits wide");
      end
   endgenerate

   bus_dec_t         dec;
   logic             busy;
   logic [BUS_W-1:0] crc;
   logic [BUS_W-1:0] ctrl_word;
   logic [BUS_W-1:0] rd_next;
   logic [BUS_W-1:0] rdata_q;

   crc_accum_regdec #(
      .ADDR_W  (ADDR_W),
      .DATA_OFS(DATA_OFS),
      .CTRL_OFS(CTRL_OFS)
   ) u_dec (
      .valid      (bus_valid),
      .we         (bus_we),
      .addr       (bus_addr),
      .restart_bit(bus_wdata[RST_BIT]),
      .dec        (dec)
   );

   crc_accum_guard #(
      .GUARD_CYC(GUARD_CYC)
   ) u_guard (
      .clk  (clk),
      .rst_n(rst_n),
      .start(dec.restart),
      .busy (busy)
   );

   crc_accum_engine #(
      .CRC_W (BUS_W),
      .DATA_W(BUS_W)
   ) u_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .reseed(dec.restart),
      .wr_en (dec.data_wr),
      .hold  (busy),
      .data  (bus_wdata),
      .crc   (crc)
   );

   always_comb begin
      ctrl_word          = '0;
      ctrl_word[RST_BIT] = busy;
      rd_next            = '0;
      if (dec.rd) begin
         unique case (dec.rd_sel)
            RSEL_DATA: rd_next = crc;
            RSEL_CTRL: rd_next = ctrl_word;
            default:   rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;

   p_ctrl_shows_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && bus_addr == ADDR_W'(CTRL_OFS) && busy)
      |=> bus_rdata[RST_BIT]);

   p_no_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_we) |=> (bus_rdata == '0));

   p_ctrl_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && bus_addr == ADDR_W'(CTRL_OFS))
      |=> ($countones(bus_rdata) <= 1));

endmodule

// File: tb/crc_accum_tb.sv
module crc_accum_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int fails  = 0;
   logic [31:0] mcrc;
   logic [31:0] r, junk;

   always #5 clk = ~clk;

   crc_accum_top dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_valid(bus_valid),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   // gap: idle cycles between restart write and data write
   localparam int NV = 8;
   localparam logic [35:0] VEC [NV] = '{
      {4'd0, 32'h1234_5678}, {4'd1, 32'hDEAD_BEEF}, {4'd2, 32'h0000_0001},
      {4'd3, 32'hA5A5_5A5A}, {4'd4, 32'h0000_0000}, {4'd1, 32'hFFFF_FFFF},
      {4'd2, 32'h8000_0000}, {4'd0, 32'h0F0F_F0F0}
   };

   function automatic logic [31:0] step(input logic [31:0] c, input logic [31:0] d);
      logic [31:0] x = c;
      for (int i = 31; i >= 0; i--) begin
         if (x[31] ^ d[i]) x = (x << 1) ^ 32'h04C1_1DB7;
         else              x = x << 1;
      end
      return x;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic bus(input logic v, input logic w, input logic [3:0] a,
                      input logic [31:0] d, output logic [31:0] rs);
      @(negedge clk);
      rs = bus_rdata;
      bus_valid = v; bus_we = w; bus_addr = a; bus_wdata = d;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      logic [31:0] t;
      bus(1'b1, 1'b1, a, d, t);
   endtask

   task automatic idle();
      logic [31:0] t;
      bus(1'b0, 1'b0, 4'h0, 32'h0, t);
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] rs);
      logic [31:0] t;
      bus(1'b1, 1'b0, a, 32'h0, t);
      bus(1'b0, 1'b0, 4'h0, 32'h0, rs);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h0, r); chk("R1 data after reset", r, 32'hFFFF_FFFF);
      rd(4'h8, r); chk("R1 ctrl after reset", r, 32'h0);
      mcrc = 32'hFFFF_FFFF;

      // R2 streaming words
      for (int i = 0; i < 4; i++) begin
         logic [31:0] w = 32'h1357_9BDF * (i + 3) ^ (32'h1 << (i * 7));
         wr(4'h0, w);
         mcrc = step(mcrc, w);
         rd(4'h0, r); chk("R2 fold word", r, mcrc);
      end
      wr(4'h0, 32'hCAFE_0001); mcrc = step(mcrc, 32'hCAFE_0001);
      wr(4'h0, 32'h0BAD_F00D); mcrc = step(mcrc, 32'h0BAD_F00D);
      rd(4'h0, r); chk("R2 back-to-back words", r, mcrc);

      // R3 reseed visible next cycle
      wr(4'h8, 32'h1);
      bus(1'b1, 1'b0, 4'h0, 32'h0, junk);
      bus(1'b0, 1'b0, 4'h0, 32'h0, r);
      chk("R3 reseed value", r, 32'hFFFF_FFFF);
      mcrc = 32'hFFFF_FFFF;
      idle();

      // R4/R5 table walk: data write placed after gap idle cycles
      for (int i = 0; i < NV; i++) begin
         logic [3:0]  gap = VEC[i][35:32];
         logic [31:0] w   = VEC[i][31:0];
         logic [31:0] ex;
         wr(4'h8, 32'h1);
         for (int k = 0; k < gap; k++) idle();
         wr(4'h0, w);
         ex = (gap >= 2) ? step(32'hFFFF_FFFF, w) : 32'hFFFF_FFFF;
         rd(4'h0, r);
         if (gap >= 2) chk("R5 write after window accepted", r, ex);
         else          chk("R4 write in window dropped", r, ex);
         mcrc = ex;
      end

      // R6 restart bit readback across the window
      wr(4'h8, 32'h1);
      rd(4'h8, r); chk("R6 bit set in cycle 1", r, 32'h1);
      wr(4'h8, 32'h1);
      idle();
      rd(4'h8, r); chk("R6 bit set in cycle 2", r, 32'h1);
      wr(4'h8, 32'h1);
      idle(); idle();
      rd(4'h8, r); chk("R6 bit cleared by hardware", r, 32'h0);

      // R7 control read inside window does not shorten it
      wr(4'h8, 32'h1);
      bus(1'b1, 1'b0, 4'h8, 32'h0, junk);
      bus(1'b1, 1'b1, 4'h0, 32'h5555_AAAA, r);
      chk("R7 ctrl read inside window", r, 32'h1);
      rd(4'h0, r); chk("R7 write after read dropped", r, 32'hFFFF_FFFF);
      mcrc = 32'hFFFF_FFFF;

      // R8 zero to restart bit
      wr(4'h0, 32'h7777_0000); mcrc = step(mcrc, 32'h7777_0000);
      wr(4'h8, 32'hFFFF_FFFE);
      wr(4'h0, 32'h0000_7777); mcrc = step(mcrc, 32'h0000_7777);
      rd(4'h0, r); chk("R8 zero write no effect", r, mcrc);
      wr(4'h8, 32'h0);
      rd(4'h8, r); chk("R8 restart bit stays 0", r, 32'h0);

      // R9 restart during window restarts it
      wr(4'h8, 32'h1);
      wr(4'h8, 32'h1);
      idle();
      wr(4'h0, 32'h2468_ACE0);
      rd(4'h0, r); chk("R9 write dropped after re-restart", r, 32'hFFFF_FFFF);
      wr(4'h8, 32'h1);
      wr(4'h8, 32'h1);
      idle(); idle();
      wr(4'h0, 32'h2468_ACE0);
      mcrc = step(32'hFFFF_FFFF, 32'h2468_ACE0);
      rd(4'h0, r); chk("R9 write accepted after full window", r, mcrc);

      // R10 read timing and unmapped reads
      rd(4'h4, r); chk("R10 unmapped read", r, 32'h0);
      wr(4'h0, 32'h1111_2222); mcrc = step(mcrc, 32'h1111_2222);
      bus(1'b0, 1'b0, 4'h0, 32'h0, r);
      chk("R10 no read gives zero", r, 32'h0);
      bus(1'b1, 1'b0, 4'h0, 32'h0, junk);
      bus(1'b1, 1'b0, 4'h8, 32'h0, r);
      chk("R10 data one cycle later", r, mcrc);
      bus(1'b0, 1'b0, 4'h0, 32'h0, r);
      chk("R10 ctrl read idle", r, 32'h0);

      // R11 unmapped writes
      wr(4'h4, 32'h1);
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'h0, r); chk("R11 unmapped write keeps crc", r, mcrc);
      rd(4'h8, r); chk("R11 unmapped write no restart", r, 32'h0);

      idle();
      finish_run();
   end

endmodule